// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a signed multiply-accumulate datapath with a 64-bit accumulator held as two 32-bit words, `acc_hi` on top of `acc_lo`. Each start strobe launches one operation. The long form multiplies two full 32-bit signed operands. The word form multiplies only the sign-extended low 16 bits of each operand. In both forms the product is added to the accumulator. When `sat_en` is set, the sum is clamped afterwards, and each form has its own clamping rule.

The product is captured in a register on the start edge. The add, the clamp and the write to the accumulator happen on the following edge, and `done` rises on that same edge. A new start may be issued in every cycle. Each operation reads the accumulator value left by the operation before it, so back-to-back starts need no stall.

Software or surrounding logic can clear the accumulator. Each word can also be loaded on its own through a shared write-data port.

A two-state controller tracks whether a registered product is waiting to be committed:
- `ST_IDLE`: no product is pending.
- `ST_BUSY`: a product was captured on the last edge and commits on the next one.

It has three transitions:
- `ST_IDLE` to `ST_BUSY` when `start` is high.
- `ST_BUSY` to `ST_BUSY` when `start` is high again.
- `ST_BUSY` to `ST_IDLE` when `start` is low.

Top module: `smac_unit`

## Requirements
- R1: After reset, `acc_hi` and `acc_lo` are zero and `done` is low.
- R2: With `op_word`=0 and `sat_en`=0, {acc_hi,acc_lo} becomes the 64-bit wrapped sum of the old value and the signed product of the full 32-bit `opa` and `opb`.
- R3: With `op_word`=1 and `sat_en`=0, only bits [15:0] of each operand are used, sign-extended, and the wrapped 64-bit sum is written. Bits [31:16] of the operands have no effect.
- R4: With `op_word`=0, `sat_en`=1 and a negative 64-bit sum, `acc_hi` takes the sum's high word with bits [31:16] forced to one. `acc_lo` takes the sum's low word.
- R5: With `op_word`=0, `sat_en`=1 and a non-negative sum, `acc_hi` takes the sum's high word ANDed with 0x00007FFF. `acc_lo` takes the sum's low word.
- R6: With `op_word`=1 and `sat_en`=1, a sum below -2^31 gives `acc_hi`=1 and `acc_lo`=0x80000000.
- R7: With `op_word`=1 and `sat_en`=1, a sum above 2^31-1 gives `acc_hi`=1 and `acc_lo`=0x7FFFFFFF.
- R8: With `op_word`=1 and `sat_en`=1, a sum in [-2^31, 2^31-1] is written unchanged, including both end points.
- R9: A start sampled on clock edge k updates the accumulator on edge k+1. `done` is high for the one cycle after edge k+1. Starts on consecutive cycles each accumulate, and `done` stays high once for each of them.
- R10: `acc_clr` zeroes both words on the next edge. It takes priority over loads and over a pending accumulation.
- R11: `hi_we` and `lo_we` each load `wr_data` into their own word on the next edge. If a load or a clear falls on the edge where an accumulation would commit, that accumulation is dropped and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one operation |
| op_word | input | 1 | 1 = 16x16 word form, 0 = 32x32 long form |
| sat_en | input | 1 | Enable the post-add clamp |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_clr | input | 1 | Synchronous accumulator clear |
| hi_we | input | 1 | Load `wr_data` into the high word |
| lo_we | input | 1 | Load `wr_data` into the low word |
| wr_data | input | 32 | Load data |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |
| done | output | 1 | One-cycle pulse when a result commits |

## Verification
The hardest situations to reach are the word-form clamp edges. Both R6 and R7 need the 64-bit sum to cross the signed 32-bit range by exactly one, and R8 needs the sum to land exactly on each end point. Products alone cannot place the accumulator there. The bench therefore first preloads the accumulator through the word load ports to a value one step from a limit, then applies a ±1 word product. The collision cases of R10 and R11 are reached by raising a clear or a load in the cycle between a start and its commit.

// File: rtl/smac_pkg.sv
package smac_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } smac_state_e;
endpackage

// File: rtl/smac_ctrl.sv
module smac_ctrl
    import smac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic block,
    output logic commit,
    output logic done
);
    smac_state_e state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_q <= start ? ST_BUSY : ST_IDLE;
                ST_BUSY: state_q <= start ? ST_BUSY : ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign commit = (state_q == ST_BUSY) && !block;

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= commit;
        end
    end
endmodule

// File: rtl/smac_mult.sv
module smac_mult #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  op_word,
    input  logic                  sat_en,
    input  logic [DW-1:0]         opa,
    input  logic [DW-1:0]         opb,
    output logic signed [2*DW-1:0] prod_q,
    output logic                  word_q,
    output logic                  sat_q
);
    localparam int AW = 2 * DW;

    logic signed [AW-1:0] a_ext;
    logic signed [AW-1:0] b_ext;
    logic signed [AW-1:0] prod_d;

    always_comb begin
        if (op_word) begin
            a_ext = AW'($signed(opa[HW-1:0]));
            b_ext = AW'($signed(opb[HW-1:0]));
        end else begin
            a_ext = AW'($signed(opa));
            b_ext = AW'($signed(opb));
        end
        prod_d = a_ext * b_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            word_q <= 1'b0;
            sat_q  <= 1'b0;
        end else if (start) begin
            prod_q <= prod_d;
            word_q <= op_word;
            sat_q  <= sat_en;
        end
    end
endmodule

// File: rtl/smac_sat.sv
module smac_sat #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [2*DW-1:0] acc,
    input  logic [2*DW-1:0] prod,
    input  logic            word,
    input  logic            sat,
    output logic [2*DW-1:0] result
);
    localparam int AW = 2 * DW;
    localparam logic signed [AW-1:0] WMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] WMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] NEG_SET  = {{HW{1'b1}}, {(DW-HW){1'b0}}};
    localparam logic [DW-1:0] POS_KEEP = {{(DW-HW+1){1'b0}}, {(HW-1){1'b1}}};
    localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};

    logic signed [AW-1:0] sum;
    logic [DW-1:0] s_hi;
    logic [DW-1:0] s_lo;

    always_comb begin
        sum    = $signed(acc) + $signed(prod);
        s_hi   = sum[AW-1:DW];
        s_lo   = sum[DW-1:0];
        result = sum;
        if (sat) begin
            if (!word) begin
                if (sum[AW-1]) result = {s_hi | NEG_SET, s_lo};
                else           result = {s_hi & POS_KEEP, s_lo};
            end else if (sum < WMIN) begin
                result = {ONE, 1'b1, {(DW-1){1'b0}}};
            end else if (sum > WMAX) begin
                result = {ONE, 1'b0, {(DW-1){1'b1}}};
            end
        end
    end
endmodule

// File: rtl/smac_unit.sv
module smac_unit #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_word,
    input  logic          sat_en,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          acc_clr,
    input  logic          hi_we,
    input  logic          lo_we,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo,
    output logic          done
);
    localparam int AW = 2 * DW;

    logic signed [AW-1:0] prod_q;
    logic                 word_q;
    logic                 sat_q;
    logic                 commit;
    logic [AW-1:0]        next_acc;

    smac_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .block  (acc_clr | hi_we | lo_we),
        .commit (commit),
        .done   (done)
    );

    smac_mult #(.DW(DW), .HW(HW)) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_word (op_word),
        .sat_en  (sat_en),
        .opa     (opa),
        .opb     (opb),
        .prod_q  (prod_q),
        .word_q  (word_q),
        .sat_q   (sat_q)
    );

    smac_sat #(.DW(DW), .HW(HW)) u_sat (
        .acc    ({acc_hi, acc_lo}),
        .prod   (prod_q),
        .word   (word_q),
        .sat    (sat_q),
        .result (next_acc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (acc_clr) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (hi_we || lo_we) begin
            if (hi_we) acc_hi <= wr_data;
            if (lo_we) acc_lo <= wr_data;
        end else if (commit) begin
            acc_hi <= next_acc[AW-1:DW];
            acc_lo <= next_acc[DW-1:0];
        end
    end
endmodule

// File: rtl/smac_unit_chk.sv
module smac_unit_chk #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          op_word,
    input logic          sat_en,
    input logic          acc_clr,
    input logic          hi_we,
    input logic          lo_we,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] acc_hi,
    input logic [DW-1:0] acc_lo,
    input logic          done
);
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2)); // R9
    AST_IDLE_HOLDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(acc_clr) && !$past(hi_we)) |-> $stable(acc_hi)); // R9
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_hi == '0 && acc_lo == '0)); // R10
    AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !acc_clr) |=> acc_hi == $past(wr_data)); // R11
    AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !acc_clr) |=> acc_lo == $past(wr_data)); // R11
    AST_LONG_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(sat_en, 2) && !$past(op_word, 2)) |->
        ((&acc_hi[DW-1:DW-HW]) || (acc_hi[DW-1:HW-1] == '0))); // R4
    AST_WORD_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(sat_en, 2) && $past(op_word, 2)) |->
        (acc_hi == '0 || acc_hi == '1 || acc_hi == DW'(1))); // R8
endmodule

bind smac_unit smac_unit_chk #(.DW(DW), .HW(HW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_word (op_word),
    .sat_en  (sat_en),
    .acc_clr (acc_clr),
    .hi_we   (hi_we),
    .lo_we   (lo_we),
    .wr_data (wr_data),
    .acc_hi  (acc_hi),
    .acc_lo  (acc_lo),
    .done    (done)
);

// File: tb/smac_unit_tb.sv
module smac_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_word = 1'b0, sat_en = 1'b0;
    logic [31:0] opa = '0, opb = '0, wr_data = '0;
    logic        acc_clr = 1'b0, hi_we = 1'b0, lo_we = 1'b0;
    logic [31:0] acc_hi, acc_lo;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] ref_acc = '0;

    always #2.5 clk = ~clk;

    smac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
        .sat_en(sat_en), .opa(opa), .opb(opb), .acc_clr(acc_clr),
        .hi_we(hi_we), .lo_we(lo_we), .wr_data(wr_data),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
    );

    function automatic logic [63:0] model(logic [63:0] acc, logic w, logic s,
                                          logic [31:0] a, logic [31:0] b);
        logic signed [63:0] p, sum;
        logic [31:0] h;
        if (w) p = 64'($signed(a[15:0])) * 64'($signed(b[15:0]));
        else   p = 64'($signed(a)) * 64'($signed(b));
        sum = $signed(acc) + p;
        if (!s) return sum;
        h = sum[63:32];
        if (!w) return sum[63] ? {h | 32'hFFFF0000, sum[31:0]} : {h & 32'h00007FFF, sum[31:0]};
        if (sum < -64'sd2147483648) return {32'd1, 32'h80000000};
        if (sum > 64'sd2147483647)  return {32'd1, 32'h7FFFFFFF};
        return sum;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_acc(logic [31:0] h, logic [31:0] l);
        @(negedge clk); hi_we = 1'b1; wr_data = h;
        @(negedge clk); hi_we = 1'b0; lo_we = 1'b1; wr_data = l;
        @(negedge clk); lo_we = 1'b0;
        ref_acc = {h, l};
        chk("R11 load", {acc_hi, acc_lo}, ref_acc);
    endtask

    task automatic run_op(string tag, logic w, logic s, logic [31:0] a, logic [31:0] b);
        @(negedge clk); start = 1'b1; op_word = w; sat_en = s; opa = a; opb = b;
        @(negedge clk); start = 1'b0;
        chk({tag, " R9 no early done"}, {63'd0, done}, 64'd0);
        @(negedge clk);
        ref_acc = model(ref_acc, w, s, a, b);
        chk({tag, " R9 done"}, {63'd0, done}, 64'd1);
        chk(tag, {acc_hi, acc_lo}, ref_acc);
        @(negedge clk);
        chk({tag, " R9 single pulse"}, {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 acc", {acc_hi, acc_lo}, 64'd0);
        chk("R1 done", {63'd0, done}, 64'd0);
    endtask

    task automatic t_long_plain();
        load_acc(32'h0000_0001, 32'hFFFF_FFF0);
        run_op("R2 pos", 1'b0, 1'b0, 32'd100, 32'd7);
        run_op("R2 neg", 1'b0, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF);
        run_op("R2 negneg", 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000);
    endtask

    task automatic t_word_plain();
        load_acc(32'h0, 32'h0);
        run_op("R3 upper ignored", 1'b1, 1'b0, 32'hABCD_0003, 32'h1234_FFFE);
        chk("R3 value", {acc_hi, acc_lo}, 64'hFFFF_FFFF_FFFF_FFFA);
        run_op("R3 min*min", 1'b1, 1'b0, 32'h0000_8000, 32'hFFFF_8000);
    endtask

    task automatic t_long_sat();
        load_acc(32'h1234_5678, 32'h0);
        run_op("R5 nonneg", 1'b0, 1'b1, 32'd5, 32'd3);
        chk("R5 value", {acc_hi, acc_lo}, 64'h0000_5678_0000_000F);
        load_acc(32'h8000_1234, 32'h0);
        run_op("R4 neg", 1'b0, 1'b1, 32'd0, 32'd9);
        chk("R4 value", {acc_hi, acc_lo}, 64'hFFFF_1234_0000_0000);
        load_acc(32'h0, 32'h0);
        run_op("R4 neg product", 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd2);
    endtask

    task automatic t_word_sat();
        load_acc(32'h0, 32'h7FFF_FFFE);
        run_op("R8 max edge", 1'b1, 1'b1, 32'd1, 32'd1);
        chk("R8 max value", {acc_hi, acc_lo}, 64'h0000_0000_7FFF_FFFF);
        run_op("R7 above", 1'b1, 1'b1, 32'd1, 32'd1);
        chk("R7 value", {acc_hi, acc_lo}, 64'h0000_0001_7FFF_FFFF);
        load_acc(32'hFFFF_FFFF, 32'h8000_0001);
        run_op("R8 min edge", 1'b1, 1'b1, 32'h0000_FFFF, 32'd1);
        chk("R8 min value", {acc_hi, acc_lo}, 64'hFFFF_FFFF_8000_0000);
        run_op("R6 below", 1'b1, 1'b1, 32'h0000_FFFF, 32'd1);
        chk("R6 value", {acc_hi, acc_lo}, 64'h0000_0001_8000_0000);
    endtask

    task automatic t_back_to_back();
        load_acc(32'h0, 32'h10);
        @(negedge clk); start = 1'b1; op_word = 1'b0; sat_en = 1'b0; opa = 32'd2; opb = 32'd3;
        @(negedge clk); opa = 32'd4; opb = 32'd5;
        @(negedge clk); opa = 32'hFFFF_FFFF; opb = 32'd1;
        chk("R9 b2b done1", {63'd0, done}, 64'd1);
        chk("R9 b2b acc1", {acc_hi, acc_lo}, 64'd22);
        @(negedge clk); start = 1'b0;
        chk("R9 b2b done2", {63'd0, done}, 64'd1);
        chk("R9 b2b acc2", {acc_hi, acc_lo}, 64'd42);
        @(negedge clk);
        chk("R9 b2b done3", {63'd0, done}, 64'd1);
        chk("R9 b2b acc3", {acc_hi, acc_lo}, 64'd41);
        @(negedge clk);
        chk("R9 b2b end", {63'd0, done}, 64'd0);
        ref_acc = 64'd41;
    endtask

    task automatic t_collisions();
        load_acc(32'h1111_1111, 32'h2222_2222);
        @(negedge clk); start = 1'b1; op_word = 1'b0; sat_en = 1'b0; opa = 32'd9; opb = 32'd9;
        @(negedge clk); start = 1'b0; acc_clr = 1'b1; hi_we = 1'b1; wr_data = 32'hDEAD_BEEF;
        @(negedge clk); acc_clr = 1'b0; hi_we = 1'b0;
        chk("R10 clear wins", {acc_hi, acc_lo}, 64'd0);
        chk("R10 no done", {63'd0, done}, 64'd0);
        load_acc(32'h1111_1111, 32'h2222_2222);
        @(negedge clk); start = 1'b1; opa = 32'd9; opb = 32'd9;
        @(negedge clk); start = 1'b0; hi_we = 1'b1; wr_data = 32'h0000_00AA;
        @(negedge clk); hi_we = 1'b0;
        chk("R11 load drops op", {acc_hi, acc_lo}, 64'h0000_00AA_2222_2222);
        chk("R11 no done", {63'd0, done}, 64'd0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long_plain();
        t_word_plain();
        t_long_sat();
        t_word_sat();
        t_back_to_back();
        t_collisions();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule